// File: doc/BRIEF.md
# NAND Access Width Adapter

This block sits between a register-style host port and an 8-bit or 16-bit NAND flash bus. The host issues single accesses of 1, 2 or 4 bytes into one of three 4-byte windows that each chip select owns: a command window, an address window and a data window. The adapter turns each access into the right number of device bus beats, marks command beats with the command-latch strobe and address beats with the address-latch strobe, and for reads packs the returned device words into one host word.

Each chip select has a configuration word on a static input. Two of its fields matter here: the device type, which decides whether the chip select is a NAND target at all, and the device width. Accesses that land outside every window, or that target a chip select not set up as NAND, finish at once with no device beat.

Both sides use valid/ready. On the host side the master raises `host_valid` with stable address, size, direction and write data and holds them until `host_ready` pulses for one cycle; `host_rdata` is valid in that cycle. It then lowers `host_valid` for at least one cycle. On the device side the adapter raises `dev_valid` with stable strobes and data and holds them until the device answers with `dev_ready`; a beat is complete on a cycle where both are high, and `dev_rdata` is taken in that cycle.

Top module: `nand_width_adapter`

## Requirements
- R1: Chip select n's configuration word is `cs_cfg[16n+15:16n]`; bits 11:10 equal to 2 mark a NAND target, and bit 12 selects the device width (0 = 8-bit, 1 = 16-bit).
- R2: On an 8-bit device, host sizes 1, 2 and 4 bytes (`host_size` 0, 1, 2; 3 acts as 4) produce 1, 2 and 4 beats, least significant byte first, each beat carrying one byte on `dev_wdata[7:0]` with the upper half zero; a read packs `dev_rdata[7:0]` of beat k into host bits 8k+7:8k.
- R3: On a 16-bit device a 2-byte access is one beat and a 4-byte access is two beats, low half first; read beat k fills host bits 16k+15:16k.
- R4: A 1-byte read from a 16-bit device makes one beat and returns only the low 8 bits of the device word; a 1-byte write to a 16-bit device makes one beat carrying `host_wdata[15:0]` unchanged.
- R5: Writes to the command window raise `dev_cle` and not `dev_ale`; writes to the address window raise `dev_ale` and not `dev_cle`; data-window accesses raise neither. `dev_we` is 1 for write beats and 0 for read beats.
- R6: Windows repeat every 0x30 bytes per chip select: command at 0x7C + 0x30·n, address at 0x80 + 0x30·n, data at 0x84 + 0x30·n, each 4 bytes wide with any byte offset inside it accepted; `dev_cs` shows n during the beats. Any other host address completes with read data 0 and no beat.
- R7: When the addressed chip select is not a NAND target, reads return 0 and writes are dropped, with no device beat.
- R8: Reads of the command or address window return 0 and make no device beat.
- R9: While `dev_valid` is high and `dev_ready` low, `dev_valid`, `dev_we`, `dev_cle`, `dev_ale`, `dev_cs` and `dev_wdata` hold; the next beat starts only after the current one completes.
- R10: `host_ready` is a single-cycle pulse issued in the cycle after the last beat completes (or the cycle after acceptance when no beat is needed), and `host_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Access complete pulse |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (12) | Byte address in the register block |
| host_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| cs_cfg | input | NUM_CS*16 (128) | Per-chip-select configuration words |
| dev_valid | output | 1 | Device beat request |
| dev_ready | input | 1 | Device beat acknowledge |
| dev_we | output | 1 | Beat direction, 1 = write |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_cs | output | CS_W (3) | Chip select of the beat |
| dev_wdata | output | 16 | Beat write data |
| dev_rdata | input | 16 | Beat read data |

## Verification
The bench aims at the size/width matrix, where a design with a wrong beat count would leave bytes unsent or invent extra beats, and a reversed lane order would swap bytes or halves in the packed read word. The two mismatched cases on a 16-bit device get their own tests: a design that widened the 1-byte read would leak the upper byte, and one that masked the 1-byte write would lose bits 15:8. Window decode is probed on a high chip select at an unaligned byte offset, where an off-by-0x30 slip would target the wrong chip or miss, and on command/address reads, non-NAND chip selects and unmapped addresses, which must finish without touching the bus. Device stalls of several cycles check that a design does not advance a beat or acknowledge the host early.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

  typedef enum logic [1:0] {
    WIN_CMD = 2'd0,
    WIN_ADR = 2'd1,
    WIN_DAT = 2'd2
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  localparam logic [1:0] TYPE_NAND = 2'd2;
  localparam int TYPE_LSB  = 10;
  localparam int WIDTH_BIT = 12;

  // number of device beats minus one
  function automatic logic [1:0] last_beat(input logic [1:0] size, input logic wide);
    logic [1:0] r;
    if (wide) r = (size >= 2'd2) ? 2'd1 : 2'd0;
    else begin
      case (size)
        2'd0:    r = 2'd0;
        2'd1:    r = 2'd1;
        default: r = 2'd3;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/nwa_win_decode.sv
module nwa_win_decode
  import nwa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CS = 8,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CS_W-1:0]   cs,
  output win_e              win
);
  localparam int GRP_STRIDE = 'h30;
  localparam int WIN_FIRST  = 'h7C;
  localparam int WIN_SPAN   = 12;

  logic [NUM_CS-1:0] grp_hit;
  logic [1:0]        grp_win [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_grp
    localparam int BASE = WIN_FIRST + g * GRP_STRIDE;
    logic [ADDR_W-1:0] off;
    assign off        = addr - ADDR_W'(BASE);
    assign grp_hit[g] = (addr >= ADDR_W'(BASE)) && (addr < ADDR_W'(BASE + WIN_SPAN));
    assign grp_win[g] = off[3:2];
  end

  always_comb begin
    hit = 1'b0;
    cs  = '0;
    win = WIN_DAT;
    for (int i = 0; i < NUM_CS; i++) begin
      if (grp_hit[i]) begin
        hit = 1'b1;
        cs  = CS_W'(i);
        win = win_e'(grp_win[i]);
      end
    end
  end

endmodule

// File: rtl/nwa_beat_seq.sv
module nwa_beat_seq
  import nwa_pkg::*;
#(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            skip,
  input  logic            op_write,
  input  logic            op_wide,
  input  logic [1:0]      op_size,
  input  logic            op_cle,
  input  logic            op_ale,
  input  logic [CS_W-1:0] op_cs,
  input  logic [31:0]     op_wdata,
  output logic            done,
  output logic [31:0]     rdata,
  output logic            dev_valid,
  input  logic            dev_ready,
  output logic            dev_we,
  output logic            dev_cle,
  output logic            dev_ale,
  output logic [CS_W-1:0] dev_cs,
  output logic [15:0]     dev_wdata,
  input  logic [15:0]     dev_rdata
);
  seq_st_e         st_q;
  logic [1:0]      beat_q, last_q;
  logic            wr_q, wide_q, byte_q, cle_q, ale_q;
  logic [CS_W-1:0] cs_q;
  logic [31:0]     wdata_q, acc_q;

  logic [4:0]  lane_sh;
  logic [15:0] rd_lane;
  logic [31:0] wr_shift, acc_next;

  always_comb begin
    lane_sh  = wide_q ? {beat_q, 3'b000} << 1 : {1'b0, beat_q, 2'b00} << 1;
    wr_shift = wdata_q >> lane_sh;
    rd_lane  = (wide_q && !byte_q) ? dev_rdata : {8'h00, dev_rdata[7:0]};
    acc_next = acc_q | (32'(rd_lane) << lane_sh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      byte_q  <= 1'b0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      cs_q    <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            st_q    <= ST_BEAT;
            beat_q  <= '0;
            last_q  <= last_beat(op_size, op_wide);
            wr_q    <= op_write;
            wide_q  <= op_wide;
            byte_q  <= (op_size == 2'd0);
            cle_q   <= op_cle;
            ale_q   <= op_ale;
            cs_q    <= op_cs;
            wdata_q <= op_wdata;
            acc_q   <= '0;
          end else if (skip) begin
            st_q  <= ST_DONE;
            acc_q <= '0;
          end
        end
        ST_BEAT: begin
          if (dev_ready) begin
            if (!wr_q) acc_q <= acc_next;
            if (beat_q == last_q) st_q <= ST_DONE;
            else beat_q <= beat_q + 2'd1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = (st_q == ST_DONE);
  assign rdata     = acc_q;
  assign dev_valid = (st_q == ST_BEAT);
  assign dev_we    = wr_q;
  assign dev_cle   = cle_q;
  assign dev_ale   = ale_q;
  assign dev_cs    = cs_q;
  assign dev_wdata = wide_q ? wr_shift[15:0] : {8'h00, wr_shift[7:0]};

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nwa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CS = 8,
  parameter int CFG_W  = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_valid,
  output logic                    host_ready,
  input  logic                    host_write,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [1:0]              host_size,
  input  logic [31:0]             host_wdata,
  output logic [31:0]             host_rdata,
  input  logic [NUM_CS*CFG_W-1:0] cs_cfg,
  output logic                    dev_valid,
  input  logic                    dev_ready,
  output logic                    dev_we,
  output logic                    dev_cle,
  output logic                    dev_ale,
  output logic [CS_W-1:0]         dev_cs,
  output logic [15:0]             dev_wdata,
  input  logic [15:0]             dev_rdata
);
  logic            win_hit;
  logic [CS_W-1:0] win_cs;
  win_e            win_sel;
  logic [CFG_W-1:0] cfg_sel;
  logic            is_nand, is_wide, needs_bus, go, skip, busy_n;

  nwa_win_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
    .addr (host_addr),
    .hit  (win_hit),
    .cs   (win_cs),
    .win  (win_sel)
  );

  always_comb begin
    cfg_sel   = cs_cfg[win_cs*CFG_W +: CFG_W];
    is_nand   = (cfg_sel[TYPE_LSB +: 2] == TYPE_NAND);
    is_wide   = cfg_sel[WIDTH_BIT];
    needs_bus = win_hit && is_nand && (host_write || (win_sel == WIN_DAT));
    go        = host_valid && busy_n && needs_bus;
    skip      = host_valid && busy_n && !needs_bus;
  end

  nwa_beat_seq #(.CS_W(CS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .skip      (skip),
    .op_write  (host_write),
    .op_wide   (is_wide),
    .op_size   (host_size),
    .op_cle    (win_sel == WIN_CMD),
    .op_ale    (win_sel == WIN_ADR),
    .op_cs     (win_cs),
    .op_wdata  (host_wdata),
    .done      (host_ready),
    .rdata     (host_rdata),
    .dev_valid (dev_valid),
    .dev_ready (dev_ready),
    .dev_we    (dev_we),
    .dev_cle   (dev_cle),
    .dev_ale   (dev_ale),
    .dev_cs    (dev_cs),
    .dev_wdata (dev_wdata),
    .dev_rdata (dev_rdata)
  );

  // accept only when neither beating nor acknowledging
  assign busy_n = !dev_valid && !host_ready;

endmodule

// File: rtl/nwa_checker.sv
module nwa_checker #(
  parameter int CS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_valid,
  input logic            host_ready,
  input logic            host_write,
  input logic            dev_valid,
  input logic            dev_ready,
  input logic            dev_we,
  input logic            dev_cle,
  input logic            dev_ale,
  input logic [CS_W-1:0] dev_cs,
  input logic [15:0]     dev_wdata
);
  logic [2:0] beats_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) beats_seen <= '0;
    else if (host_ready) beats_seen <= '0;
    else if (dev_valid && dev_ready && beats_seen != 3'd7) beats_seen <= beats_seen + 3'd1;
  end

  // R9: a stalled beat keeps every strobe and data stable
  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_we) && $stable(dev_cle)
      && $stable(dev_ale) && $stable(dev_cs) && $stable(dev_wdata));

  // R5: command and address strobes never together, and only on writes
  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> !(dev_cle && dev_ale) && (!(dev_cle || dev_ale) || dev_we));

  // R10: host acknowledge is a single-cycle pulse, never during a beat
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !dev_valid);

  // R10: a completed last beat leads to the acknowledge, beats only for a live request
  p_beat_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_valid) |-> $past(host_valid));

  // R2: no access produces more than four beats
  p_beat_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beats_seen <= 3'd4);

  // R5: beat direction follows the held host direction
  p_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && host_valid |-> dev_we == host_write);

endmodule

bind nand_width_adapter nwa_checker #(.CS_W(CS_W)) u_nwa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_write (host_write),
  .dev_valid  (dev_valid),
  .dev_ready  (dev_ready),
  .dev_we     (dev_we),
  .dev_cle    (dev_cle),
  .dev_ale    (dev_ale),
  .dev_cs     (dev_cs),
  .dev_wdata  (dev_wdata)
);

// File: tb/nand_width_adapter_bench.sv
module nand_width_adapter_bench;
  localparam int ADDR_W = 12;
  localparam int NUM_CS = 8;
  localparam int CFG_W  = 16;
  localparam int CS_W   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic host_ready;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [NUM_CS*CFG_W-1:0] cs_cfg = '0;
  logic dev_valid, dev_we, dev_cle, dev_ale;
  logic dev_ready = 1'b0;
  logic [CS_W-1:0] dev_cs;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = '0;

  always #2 clk = ~clk;

  nand_width_adapter u_nand_width_adapter (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cs_cfg(cs_cfg),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_we(dev_we),
    .dev_cle(dev_cle), .dev_ale(dev_ale), .dev_cs(dev_cs),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int dev_lat = 0;
  int wait_cnt = 0;
  int lg_n = 0;
  logic [15:0] lg_dat [8];
  logic        lg_cle [8];
  logic        lg_ale [8];
  logic        lg_we  [8];
  logic [2:0]  lg_cs  [8];
  logic [31:0] got_rdata;
  bit stalled_early = 1'b0;

  function automatic logic [15:0] pat(int k);
    return 16'(16'hA1B2 + k * 16'h1111);
  endfunction

  // device model: sampled and driven on the falling edge
  always @(negedge clk) begin
    if (dev_ready) dev_ready <= 1'b0;
    else if (dev_valid) begin
      if (wait_cnt >= dev_lat) begin
        if (lg_n < 8) begin
          lg_dat[lg_n] = dev_wdata;
          lg_cle[lg_n] = dev_cle;
          lg_ale[lg_n] = dev_ale;
          lg_we[lg_n]  = dev_we;
          lg_cs[lg_n]  = dev_cs;
        end
        dev_rdata <= pat(lg_n);
        lg_n      = lg_n + 1;
        dev_ready <= 1'b1;
        wait_cnt  = 0;
      end else begin
        wait_cnt = wait_cnt + 1;
        if (host_ready) stalled_early = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int cs, input logic [15:0] v);
    cs_cfg[cs*CFG_W +: CFG_W] = v;
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [1:0] sz, input logic [31:0] wd);
    int guard;
    @(negedge clk);
    lg_n = 0;
    host_write = wr; host_addr = a; host_size = sz; host_wdata = wd;
    host_valid = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!host_ready && guard < 200);
    got_rdata = host_rdata;
    host_valid = 1'b0;
    if (!host_ready) check("R10 timeout", 32'd0, 32'd1);
  endtask

  localparam logic [15:0] CFG_N8  = 16'h0800;
  localparam logic [15:0] CFG_N16 = 16'h1800;
  localparam logic [15:0] CFG_NOR = 16'h0000;
  localparam logic [15:0] CFG_T3  = 16'h1C00;

  function automatic logic [ADDR_W-1:0] wa(int cs, int w, int b);
    return ADDR_W'('h7C + cs * 'h30 + w * 4 + b);
  endfunction

  task automatic t_reset;
    check("R10 reset host_ready", 32'(host_ready), 32'd0);
    check("R9 reset dev_valid", 32'(dev_valid), 32'd0);
  endtask

  task automatic t_narrow;
    dev_lat = 1;
    access(1'b1, wa(0, 2, 0), 2'd2, 32'hDDCCBBAA);
    check("R2 w4 beat count", 32'(lg_n), 32'd4);
    check("R2 w4 lane order", {lg_dat[3][7:0], lg_dat[2][7:0], lg_dat[1][7:0], lg_dat[0][7:0]}, 32'hDDCCBBAA);
    check("R2 upper zero", 32'(lg_dat[1][15:8]), 32'd0);
    check("R5 data write no strobes", {30'd0, lg_cle[0], lg_ale[0]}, 32'd0);
    check("R5 write dir", 32'(lg_we[2]), 32'd1);
    access(1'b1, wa(0, 2, 0), 2'd1, 32'h00001234);
    check("R2 w2 beat count", 32'(lg_n), 32'd2);
    check("R2 w2 data", {lg_dat[1][7:0], lg_dat[0][7:0]}, 32'h1234);
    access(1'b1, wa(0, 2, 0), 2'd0, 32'h000000E7);
    check("R2 w1 beat count", 32'(lg_n), 32'd1);
    check("R2 w1 data", 32'(lg_dat[0]), 32'h00E7);
    access(1'b0, wa(0, 2, 0), 2'd2, 32'h0);
    check("R2 r4 beat count", 32'(lg_n), 32'd4);
    check("R2 r4 packing", got_rdata, 32'hE5D4C3B2);
    check("R5 read dir", 32'(lg_we[0]), 32'd0);
    access(1'b0, wa(0, 2, 1), 2'd1, 32'h0);
    check("R2 r2 packing", got_rdata, 32'h0000C3B2);
  endtask

  task automatic t_wide;
    dev_lat = 0;
    access(1'b1, wa(3, 2, 0), 2'd2, 32'h89AB4567);
    check("R3 w4 beat count", 32'(lg_n), 32'd2);
    check("R3 w4 halves", {lg_dat[1], lg_dat[0]}, 32'h89AB4567);
    check("R1 cs output", 32'(lg_cs[0]), 32'd3);
    access(1'b1, wa(3, 2, 0), 2'd1, 32'h0000BEEF);
    check("R3 w2 beat count", 32'(lg_n), 32'd1);
    check("R3 w2 data", 32'(lg_dat[0]), 32'hBEEF);
    access(1'b0, wa(3, 2, 0), 2'd2, 32'h0);
    check("R3 r4 packing", got_rdata, 32'hB2C3A1B2);
    access(1'b0, wa(3, 2, 0), 2'd1, 32'h0);
    check("R3 r2 beats", 32'(lg_n), 32'd1);
    check("R3 r2 data", got_rdata, 32'h0000A1B2);
  endtask

  task automatic t_wide_byte;
    dev_lat = 2;
    access(1'b0, wa(3, 2, 0), 2'd0, 32'h0);
    check("R4 r1 beats", 32'(lg_n), 32'd1);
    check("R4 r1 low byte", got_rdata, 32'h000000B2);
    access(1'b1, wa(3, 2, 0), 2'd0, 32'h5555C3A7);
    check("R4 w1 beats", 32'(lg_n), 32'd1);
    check("R4 w1 unchanged", 32'(lg_dat[0]), 32'hC3A7);
  endtask

  task automatic t_windows;
    dev_lat = 1;
    access(1'b1, wa(7, 0, 1), 2'd0, 32'h00000070);
    check("R5 cmd cle", {30'd0, lg_cle[0], lg_ale[0]}, 32'd2);
    check("R6 cmd cs7 unaligned", 32'(lg_cs[0]), 32'd7);
    check("R6 cmd data", 32'(lg_dat[0]), 32'h0070);
    access(1'b1, wa(7, 1, 3), 2'd1, 32'h00000201);
    check("R5 addr ale", {30'd0, lg_cle[1], lg_ale[1]}, 32'd1);
    check("R5 addr beats", 32'(lg_n), 32'd2);
    access(1'b0, wa(7, 0, 0), 2'd2, 32'h0);
    check("R8 cmd read no beat", 32'(lg_n), 32'd0);
    check("R8 cmd read zero", got_rdata, 32'd0);
    access(1'b0, wa(7, 1, 0), 2'd2, 32'h0);
    check("R8 addr read zero", {got_rdata[31:1], 1'b0} | 32'(lg_n), 32'd0);
    access(1'b0, ADDR_W'('h078), 2'd2, 32'h0);
    check("R6 below window no beat", 32'(lg_n) | got_rdata, 32'd0);
    access(1'b1, ADDR_W'('h088), 2'd2, 32'hFFFFFFFF);
    check("R6 above window no beat", 32'(lg_n), 32'd0);
  endtask

  task automatic t_non_nand;
    dev_lat = 0;
    access(1'b0, wa(2, 2, 0), 2'd2, 32'h0);
    check("R7 nor read zero", got_rdata, 32'd0);
    check("R7 nor read no beat", 32'(lg_n), 32'd0);
    access(1'b1, wa(2, 0, 0), 2'd0, 32'h000000FF);
    check("R7 nor cmd dropped", 32'(lg_n), 32'd0);
    access(1'b1, wa(5, 2, 0), 2'd2, 32'h12345678);
    check("R1 type3 dropped", 32'(lg_n), 32'd0);
  endtask

  task automatic t_stall;
    dev_lat = 4;
    stalled_early = 1'b0;
    access(1'b0, wa(0, 2, 0), 2'd2, 32'h0);
    check("R10 no early ack", 32'(stalled_early), 32'd0);
    check("R9 stalled packing", got_rdata, 32'hE5D4C3B2);
  endtask

  bit finished = 1'b0;

  initial begin
    set_cfg(0, CFG_N8);
    set_cfg(2, CFG_NOR);
    set_cfg(3, CFG_N16);
    set_cfg(5, CFG_T3);
    set_cfg(7, CFG_N8);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_narrow;
    t_wide;
    t_wide_byte;
    t_windows;
    t_non_nand;
    t_stall;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule